// File: doc/BRIEF.md
# Memory Controller Control/Status Register File

This block is the register-access slave of one memory controller. A simple bus with separate read and write strobes, a byte address, a transfer size and 32-bit write data reaches three or four 32-bit control/status registers and a read-only configuration ROM window. One cycle after each strobe the block gives exactly one of three responses, or none at all for an accepted write:
- read data with a valid pulse,
- a non-existent-register pulse,
- an error-confirmation pulse for a malformed transfer.

The registers use several field behaviours:
- Some fields are written only when an enable bit in the same write data is set.
- Reads pass through a per-register mask, and one register always reads two bits as ones.
- Error bits are cleared by writing a one to them.

Hardware sets the error bits through per-bit set inputs. A write-one-to-clear in the same cycle takes priority over a set. The basic or extended build variant is chosen at elaboration. The variant changes the reset values and the masks, and decides whether the fourth register exists. The controller index, the array size and the ROM image are also elaboration parameters.

Top module: `mem_csr_file`

## Requirements
- R1: The longword offset is address bits [ADDR_W-1:2]. Register A is at offset 0, B at 1, C at 2 and D at 3. A read with `rd_i` raised returns its data on `rdata_o` with `rvalid_o` high in the cycle after the strobe. When `rd_i` and `wr_i` are both high, only the write is performed.
- R2: A transfer is malformed when address bits [1:0] are non-zero or when `size_i` is not 2 (size encoding: 0 = byte, 1 = word, 2 = longword, 3 = reserved). A malformed transfer pulses `errcnf_o` for one cycle after the strobe and changes no register.
- R3: `nxm_o` pulses for one cycle after the strobe in each of these cases:
  - a well-formed read or write to any offset not listed in R1 or R11;
  - any access to register D in the basic variant;
  - any write into the ROM window.
- R4: In register A, bit 8 is always written. Bits 2:0 are written only when the write data has bit 8 set. Reads of A return only bits 14:0.
- R5: In register B, bits 9:0 and bit 14 are always written. Bits 27:15 are written only when the write data has bit 14 set. No other bit of B is writable.
- R6: A read of register B always returns bits 13:12 as ones and bit 11 as zero.
- R7: In register C, bit 30 is an ordinary read/write bit. Writing a one clears error bits 29:28. In the extended variant, writing a one also clears bits 19, 18, 9, 8 and 7.
- R8: Register C reads through mask 0x7FFFFFFF in the basic variant and 0x700C0380 in the extended variant. In the extended variant, register D behaves like extended C under the same mask.
- R9: A one on `err_set_c_i` or `err_set_d_i` at a clearable error-bit position sets that bit. A write-one-to-clear of the same bit in the same cycle wins. Set inputs at other positions have no effect.
- R10: Reset values differ by variant:
  - basic: A = 0x7E10 and B = 0x3000 | (CTRL_IDX << 21);
  - extended: A = ((ARRAY_MB-1) << 9) | 0x6A and B = 0x3000 | ((CTRL_IDX*ARRAY_MB) << 19);
  - both variants: C and D reset to 0.
- R11: Offsets 0x400 to 0x400+ROM_WORDS-1 read word (offset-0x400) of the ROM image. Word i is `ROM_IMAGE[32*i+31:32*i]`.
- R12: At most one of `rvalid_o`, `nxm_o` and `errcnf_o` is high in any cycle. `rdata_o` is zero whenever `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address within the controller space |
| size_i | input | 2 | Transfer size (2 = longword) |
| wdata_i | input | 32 | Write data |
| err_set_c_i | input | 32 | Per-bit error set for register C |
| err_set_d_i | input | 32 | Per-bit error set for register D |
| rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| rdata_o | output | 32 | Read data |
| nxm_o | output | 1 | Non-existent register response |
| errcnf_o | output | 1 | Error-confirmation response for a malformed transfer |

## Verification
The assertions check the following on every cycle:
- the response is exclusive and arrives with one cycle of latency;
- malformed transfers leave A and B untouched;
- the gated fields in A and B keep their value when the gating bit is clear;
- the forced and hidden bits of a B read are correct;
- write-one-to-clear beats the error set.

Other behaviours can only be shown by the bench's scenarios, which run both variants side by side:
- the exact reset values;
- the variant-specific read masks and clearable bits;
- the absence of register D in the basic variant;
- ROM contents and the ROM window bounds;
- that writes with both strobes high produce no read response.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} size_e;
  typedef enum logic [2:0] {SEL_A, SEL_B, SEL_C, SEL_D, SEL_ROM, SEL_NONE} sel_e;

  localparam int          ROM_BASE    = 1024;
  localparam logic [31:0] A_RD_MASK   = 32'h0000_7FFF;
  localparam logic [31:0] A_WR_FIX    = 32'h0000_0100;
  localparam logic [31:0] A_ILV       = 32'h0000_0007;
  localparam logic [31:0] B_RD_MASK   = 32'hFFFF_F7FF;
  localparam logic [31:0] B_FORCE     = 32'h0000_3000;
  localparam logic [31:0] B_WR_FIX    = 32'h0000_43FF;
  localparam logic [31:0] B_SA        = 32'h0FFF_8000;
  localparam logic [31:0] C_RW        = 32'h4000_0000;
  localparam logic [31:0] C_W1C_BASIC = 32'h3000_0000;
  localparam logic [31:0] C_W1C_EXT   = 32'h300C_0380;
  localparam logic [31:0] C_RD_BASIC  = 32'h7FFF_FFFF;
  localparam logic [31:0] C_RD_EXT    = 32'h700C_0380;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int ROM_WORDS = 16,
  parameter bit EXTENDED  = 1'b0,
  localparam int OFS_W    = ADDR_W - 2,
  localparam int RIDX_W   = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              bad_form_o,
  output sel_e              sel_o,
  output logic [RIDX_W-1:0] rom_idx_o
);
  logic [OFS_W-1:0] ofs, ofs_rel;

  assign ofs        = addr_i[ADDR_W-1:2];
  assign ofs_rel    = ofs - OFS_W'(ROM_BASE);
  assign bad_form_o = (addr_i[1:0] != 2'b00) || (size_e'(size_i) != SZ_LONG);
  assign rom_idx_o  = ofs_rel[RIDX_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (ofs == OFS_W'(0))                       sel_o = SEL_A;
    else if (ofs == OFS_W'(1))                  sel_o = SEL_B;
    else if (ofs == OFS_W'(2))                  sel_o = SEL_C;
    else if (ofs == OFS_W'(3) && EXTENDED)      sel_o = SEL_D;
    else if (32'(ofs) >= 32'(ROM_BASE) &&
             32'(ofs) <  32'(ROM_BASE + ROM_WORDS)) sel_o = SEL_ROM;
  end

  // R3: register D never decodes in the basic variant
  always_comb begin
    if (!EXTENDED) a_r3_no_d_basic: assert (sel_o != SEL_D);
  end
endmodule

// File: rtl/mcsr_rom.sv
module mcsr_rom #(
  parameter int                     ROM_WORDS = 16,
  parameter logic [ROM_WORDS*32-1:0] ROM_IMAGE = '0,
  localparam int                    RIDX_W    = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1
) (
  input  logic [RIDX_W-1:0] idx_i,
  output logic [31:0]       data_o
);
  logic [31:0] words [ROM_WORDS];

  for (genvar i = 0; i < ROM_WORDS; i++) begin : g_word
    assign words[i] = ROM_IMAGE[32*i +: 32];
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < ROM_WORDS; i++)
      if (32'(idx_i) == i) data_o = words[i];
  end
endmodule

// File: rtl/mcsr_err_reg.sv
module mcsr_err_reg
  import mcsr_pkg::*;
#(
  parameter logic [31:0] W1C_MASK = C_W1C_BASIC,
  parameter logic [31:0] RD_MASK  = C_RD_BASIC
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] set_i,
  output logic [31:0] rdata_o
);
  logic [31:0] q, d;

  always_comb begin
    d = q | (set_i & W1C_MASK);
    if (wr_en_i) begin
      d = (d & ~C_RW) | (wdata_i & C_RW);
      d = d & ~(wdata_i & W1C_MASK);   // clear beats same-cycle set
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= d;

  assign rdata_o = q & RD_MASK;

  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && |(wdata_i & W1C_MASK)) |=> ((q & $past(wdata_i & W1C_MASK)) == '0));
  a_r9_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && |(set_i & W1C_MASK)) |=> ((q & $past(set_i & W1C_MASK)) == $past(set_i & W1C_MASK)));
  a_r7_rw_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (q[30] == $past(wdata_i[30])));
endmodule

// File: rtl/mem_csr_file.sv
module mem_csr_file
  import mcsr_pkg::*;
#(
  parameter bit                      EXTENDED  = 1'b0,
  parameter int                      CTRL_IDX  = 0,
  parameter int                      ARRAY_MB  = 4,
  parameter int                      ADDR_W    = 13,
  parameter int                      ROM_WORDS = 16,
  parameter logic [ROM_WORDS*32-1:0] ROM_IMAGE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       err_set_c_i,
  input  logic [31:0]       err_set_d_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic              nxm_o,
  output logic              errcnf_o
);
  localparam int          RIDX_W = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1;
  localparam logic [31:0] A_RST  = EXTENDED ? ((32'(ARRAY_MB - 1) << 9) | 32'h6A) : 32'h7E10;
  localparam logic [31:0] B_RST  = B_FORCE |
    (EXTENDED ? (32'(CTRL_IDX * ARRAY_MB) << 19) : (32'(CTRL_IDX) << 21));
  localparam logic [31:0] C_W1C  = EXTENDED ? C_W1C_EXT : C_W1C_BASIC;
  localparam logic [31:0] C_RD   = EXTENDED ? C_RD_EXT  : C_RD_BASIC;

  logic              do_rd, do_wr, bad_form;
  sel_e              sel;
  logic [RIDX_W-1:0] rom_idx;
  logic [31:0]       rom_data, c_rdata, d_rdata, rd_val;
  logic [31:0]       reg_a, reg_b, mask_a, mask_b;
  logic              wr_ok;

  assign do_wr = wr_i;
  assign do_rd = rd_i & ~wr_i;
  assign wr_ok = do_wr & ~bad_form;

  mcsr_decode #(.ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS), .EXTENDED(EXTENDED)) i_decode (
    .addr_i(addr_i), .size_i(size_i),
    .bad_form_o(bad_form), .sel_o(sel), .rom_idx_o(rom_idx)
  );

  mcsr_rom #(.ROM_WORDS(ROM_WORDS), .ROM_IMAGE(ROM_IMAGE)) i_rom (
    .idx_i(rom_idx), .data_o(rom_data)
  );

  mcsr_err_reg #(.W1C_MASK(C_W1C), .RD_MASK(C_RD)) i_reg_c (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_ok && sel == SEL_C), .wdata_i(wdata_i),
    .set_i(err_set_c_i), .rdata_o(c_rdata)
  );

  if (EXTENDED) begin : g_reg_d
    mcsr_err_reg #(.W1C_MASK(C_W1C_EXT), .RD_MASK(C_RD_EXT)) i_reg_d (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_ok && sel == SEL_D), .wdata_i(wdata_i),
      .set_i(err_set_d_i), .rdata_o(d_rdata)
    );
  end else begin : g_no_d
    assign d_rdata = '0;
  end

  // gated-write masks for A and B
  assign mask_a = A_WR_FIX | (wdata_i[8]  ? A_ILV : '0);
  assign mask_b = B_WR_FIX | (wdata_i[14] ? B_SA  : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a <= A_RST;
      reg_b <= B_RST;
    end else if (wr_ok) begin
      if (sel == SEL_A) reg_a <= (reg_a & ~mask_a) | (wdata_i & mask_a);
      if (sel == SEL_B) reg_b <= (reg_b & ~mask_b) | (wdata_i & mask_b);
    end
  end

  always_comb begin
    unique case (sel)
      SEL_A:   rd_val = reg_a & A_RD_MASK;
      SEL_B:   rd_val = (reg_b & B_RD_MASK) | B_FORCE;
      SEL_C:   rd_val = c_rdata;
      SEL_D:   rd_val = d_rdata;
      SEL_ROM: rd_val = rom_data;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      nxm_o    <= 1'b0;
      errcnf_o <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      nxm_o    <= 1'b0;
      errcnf_o <= 1'b0;
      if (do_rd || do_wr) begin
        if (bad_form)                                  errcnf_o <= 1'b1;
        else if (sel == SEL_NONE || (do_wr && sel == SEL_ROM)) nxm_o <= 1'b1;
        else if (do_rd) begin
          rvalid_o <= 1'b1;
          rdata_o  <= rd_val;
        end
      end
    end
  end

  a_r12_one_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rvalid_o, nxm_o, errcnf_o}));
  a_r12_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
  a_r2_errcnf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && bad_form) |=> errcnf_o);
  a_r2_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bad_form) |=> ($stable(reg_a) && $stable(reg_b)));
  a_r1_read_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rd && !bad_form && sel != SEL_NONE) |=> rvalid_o);
  a_r3_nxm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !bad_form && sel == SEL_NONE) |=> nxm_o);
  a_r4_ilv_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdata_i[8]) |=> (reg_a[2:0] == $past(reg_a[2:0])));
  a_r5_sa_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdata_i[14]) |=> (reg_b[27:15] == $past(reg_b[27:15])));
  a_r6_b_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rd && !bad_form && sel == SEL_B) |=> (rdata_o[13:12] == 2'b11 && !rdata_o[11]));
endmodule

// File: tb/test_mem_csr_file.sv
`timescale 1ns/1ps
module test_mem_csr_file;
  localparam int ROMN = 4;
  localparam logic [ROMN*32-1:0] ROM_IMG =
    {32'hDEAD_0003, 32'h1234_5602, 32'h0F0F_0001, 32'hA5A5_0000};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd = 0, wr = 0;
  logic [12:0] addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0, set_c = '0, set_d = '0;
  logic        rv [2];
  logic        nx [2];
  logic        ec [2];
  logic [31:0] rdat [2];

  int checks = 0, fails = 0;
  logic [31:0] m_a [2], m_b [2], m_c [2], m_d [2];

  always #4 clk = ~clk;

  mem_csr_file #(.EXTENDED(1'b0), .CTRL_IDX(1), .ARRAY_MB(4), .ADDR_W(13),
                 .ROM_WORDS(ROMN), .ROM_IMAGE(ROM_IMG)) i_mem_csr_file (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .err_set_c_i(set_c), .err_set_d_i(set_d),
    .rvalid_o(rv[0]), .rdata_o(rdat[0]), .nxm_o(nx[0]), .errcnf_o(ec[0]));

  mem_csr_file #(.EXTENDED(1'b1), .CTRL_IDX(2), .ARRAY_MB(4), .ADDR_W(13),
                 .ROM_WORDS(ROMN), .ROM_IMAGE(ROM_IMG)) i_mem_csr_file_ext (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .err_set_c_i(set_c), .err_set_d_i(set_d),
    .rvalid_o(rv[1]), .rdata_o(rdat[1]), .nxm_o(nx[1]), .errcnf_o(ec[1]));

  function automatic logic [31:0] w1c(int v);
    return v ? 32'h300C_0380 : 32'h3000_0000;
  endfunction
  function automatic logic [31:0] rom_word(int i);
    case (i)
      0: return 32'hA5A5_0000;
      1: return 32'h0F0F_0001;
      2: return 32'h1234_5602;
      default: return 32'hDEAD_0003;
    endcase
  endfunction

  task automatic model_reset();
    m_a[0] = 32'h7E10;  m_a[1] = 32'h066A;        // R10
    m_b[0] = 32'h0020_3000; m_b[1] = 32'h0040_3000;
    for (int v = 0; v < 2; v++) begin m_c[v] = '0; m_d[v] = '0; end
  endtask

  task automatic chk(string req, int v, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dut%0d %s actual=%h expected=%h", req, v, what, act, exp);
    end
  endtask

  function automatic string tag_of(int ofs, bit bad);
    if (bad) return "R2";
    case (ofs)
      0: return "R4"; 1: return "R6"; 2: return "R7"; 3: return "R8";
      default: return (ofs >= 1024 && ofs < 1024 + ROMN) ? "R11" : "R3";
    endcase
  endfunction

  // one bus cycle; expected values from the requirement model
  task automatic access(bit r, bit w, logic [12:0] a, logic [1:0] s, logic [31:0] d,
                        logic [31:0] sc, logic [31:0] sd);
    int ofs = int'(a[12:2]);
    bit bad = (a[1:0] != 2'b00) || (s != 2'd2);
    logic [2:0]  ekind [2];
    logic [31:0] edata [2];
    string tg = tag_of(ofs, bad);
    for (int v = 0; v < 2; v++) begin
      bit known = (ofs <= 2) || (ofs == 3 && v == 1) || (ofs >= 1024 && ofs < 1024 + ROMN);
      bit wable = (ofs <= 2) || (ofs == 3 && v == 1);
      ekind[v] = 3'b000; edata[v] = '0;
      if (r || w) begin
        if (bad) ekind[v] = 3'b100;
        else if (w ? !wable : !known) ekind[v] = 3'b010;
        else if (!w) begin
          ekind[v] = 3'b001;
          case (ofs)
            0: edata[v] = m_a[v] & 32'h7FFF;
            1: edata[v] = (m_b[v] & 32'hFFFF_F7FF) | 32'h3000;
            2: edata[v] = m_c[v] & (v ? 32'h700C_0380 : 32'h7FFF_FFFF);
            3: edata[v] = m_d[v] & 32'h700C_0380;
            default: edata[v] = rom_word(ofs - 1024);
          endcase
        end
      end
    end
    @(negedge clk);
    rd = r; wr = w; addr = a; size = s; wdata = d; set_c = sc; set_d = sd;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk(tg, v, {29'd0, ec[v], nx[v], rv[v]}, {29'd0, ekind[v]}, "resp{ec,nx,rv}");
      chk(tg, v, rdat[v], edata[v], "rdata (R12 when not valid)");
    end
    rd = 0; wr = 0; set_c = '0; set_d = '0;
    for (int v = 0; v < 2; v++) begin
      bit wv = w && !bad;
      logic [31:0] mk;
      if (wv && ofs == 0) begin
        mk = 32'h100 | (d[8] ? 32'h7 : 32'h0);
        m_a[v] = (m_a[v] & ~mk) | (d & mk);
      end
      if (wv && ofs == 1) begin
        mk = 32'h43FF | (d[14] ? 32'h0FFF_8000 : 32'h0);
        m_b[v] = (m_b[v] & ~mk) | (d & mk);
      end
      m_c[v] = m_c[v] | (sc & w1c(v));
      if (wv && ofs == 2)
        m_c[v] = ((m_c[v] & ~32'h4000_0000) | (d & 32'h4000_0000)) & ~(d & w1c(v));
      if (v == 1) begin
        m_d[v] = m_d[v] | (sd & w1c(1));
        if (wv && ofs == 3)
          m_d[v] = ((m_d[v] & ~32'h4000_0000) | (d & 32'h4000_0000)) & ~(d & w1c(1));
      end
    end
  endtask

  task automatic rdl(int ofs);
    access(1, 0, 13'(ofs << 2), 2'd2, '0, '0, '0);
  endtask
  task automatic wrl(int ofs, logic [31:0] d);
    access(0, 1, 13'(ofs << 2), 2'd2, d, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    for (int v = 0; v < 2; v++)
      chk("R12", v, {29'd0, ec[v], nx[v], rv[v]}, '0, "idle in reset");
    rst_n = 1'b1;
    // R10 R1: reset values
    for (int o = 0; o < 4; o++) rdl(o);
    // R4: interleave field gated by bit 8
    wrl(0, 32'h0000_0005);  rdl(0);
    wrl(0, 32'h0000_0105);  rdl(0);
    wrl(0, 32'hFFFF_FEF8);  rdl(0);
    // R5 R6: start-address gated by bit 14, forced/hidden bits
    wrl(1, 32'h0FFF_8BFF);  rdl(1);
    wrl(1, 32'h0AAA_CC55);  rdl(1);
    wrl(1, 32'h0000_0000);  rdl(1);
    // R7 R8 R9: C and D error bits
    wrl(2, 32'h4000_0000);  rdl(2);
    access(0, 0, '0, 2'd2, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rdl(2); rdl(3);
    wrl(2, 32'h1008_0100);  rdl(2);
    wrl(3, 32'h2004_0080);  rdl(3);
    // R9: clear and set of the same bit in one cycle; clear wins
    access(0, 1, 13'h8, 2'd2, 32'h3000_0000, 32'h3000_0200, 32'h0);
    rdl(2);
    access(0, 1, 13'hC, 2'd2, 32'h0000_0200, 32'h0, 32'h0000_0300);
    rdl(3);
    // R2: malformed transfers change nothing
    access(0, 1, 13'h1, 2'd2, 32'h0000_0107, '0, '0);
    access(0, 1, 13'h0, 2'd0, 32'h0000_0107, '0, '0);
    access(1, 0, 13'h6, 2'd2, '0, '0, '0);
    access(1, 0, 13'h4, 2'd3, '0, '0, '0);
    rdl(0);
    // R11 R3: ROM window and holes
    for (int i = 0; i < ROMN; i++) rdl(1024 + i);
    rdl(1024 + ROMN); wrl(1025, 32'h1); rdl(1025);
    rdl(5); wrl(9, 32'hFFFF_FFFF); rdl(1023);
    // R1: both strobes: write only
    access(1, 1, 13'h0, 2'd2, 32'h0000_0102, '0, '0);
    rdl(0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int pick = $urandom_range(0, 9);
      int ofs;
      logic [12:0] a;
      logic [1:0]  s = 2'd2;
      logic [31:0] sc = '0, sd = '0;
      case (pick)
        0, 1, 2, 3: ofs = pick;
        4, 5, 6, 7: ofs = 1024 + pick - 4;
        8: ofs = 1024 + ROMN;
        default: ofs = 7;
      endcase
      a = 13'(ofs << 2);
      if ($urandom_range(0, 7) == 0) begin
        if ($urandom_range(0, 1) == 0) a[1:0] = 2'($urandom_range(1, 3));
        else s = 2'($urandom_range(0, 1) == 0 ? 0 : 3);
      end
      if ($urandom_range(0, 3) == 0) begin
        sc = $urandom() & $urandom();
        sd = $urandom() & $urandom();
      end
      access($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, s,
             $urandom(), sc, sd);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule